// File: doc/BRIEF.md
# Successor-Linked Control Sequencer

This block steers an external processing unit without a program counter. Control lives in a registered pin-address bus. Each cycle the pin named on that bus fires, and every firing pin names the pin that comes after it. A send pin drives an operation code and an operand onto the buses toward the processing unit. An open pin waits for the unit's answer. The unit returns its result on an answer bus, together with a one-hot condition flag. That flag picks one of three branch pins that belong to the register being answered, and the chosen branch pin supplies the next address.

All control state (the operation codes, the successor addresses of the send pins and the successor addresses of the branch pins) arrives as one wide frame on a load port. When a pin address names a different frame, the block asks for that frame and stalls until the frame is delivered. Loading a frame never touches the data registers, so results carry over from one frame to the next. Out of reset the block asks for frame 0, and once it is loaded, execution begins at local pin 0.

Top module: `pinseq_top`

## Requirements
- R1: In reset, and in the first cycle after it, load_req is 1, load_frame is 0, pin_addr is 0, err is 0 and send_valid is 0. All data registers reset to 0.
- R2: When load_done is high while load_req is high, frame_bits replace every control register and the requested frame becomes the current frame. In the next cycle the pin at pin_addr fires. frame_bits layout: operation code of register r, slot s at [(2r+s)*4 +: 4]. Send successor of (r,s) at [64+(2r+s)*10 +: 10]. Branch successor of register r, condition c at [224+(3r+c)*10 +: 10].
- R3: pin_addr is {frame[3:0], local[5:0]}. local[5:4] gives the pin kind: 00 is send with slot 0, 01 is send with slot 1, 10 is open, 11 is halt. local[2:0] is the register index.
- R4: A send pin raises send_valid for exactly its cycle. In that cycle it drives fc_out with that register's slot code and data_out with that data register. In the next cycle pin_addr holds the pin's send successor.
- R5: An open pin selects its register and raises ans_wait from the next cycle on. It has no successor of its own.
- R6: While ans_wait is high, a one-hot cc_bus (bit 0 less than zero, bit 1 zero, bit 2 greater than zero) writes answer into the selected data register. In the next cycle pin_addr holds that register's branch successor for the flagged condition.
- R7: While ans_wait is high and cc_bus is 0, the block keeps waiting and pin_addr stays unchanged.
- R8: A frame field of 0 means the current frame. A nonzero field that differs from the current frame raises load_req with load_frame equal to that field, fires no pin, and holds pin_addr until load_done arrives.
- R9: Data registers keep their values across a frame load, including a value written in the same cycle as the branch that leads to the load.
- R10: A cc_bus with more than one bit set while waiting sets err. err stays set until reset, the state is frozen, and any later cc_bus value is ignored.
- R11: A halt pin keeps pin_addr unchanged and raises no send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_addr | output | 10 | Registered pin-address bus |
| send_valid | output | 1 | A send pin is firing this cycle |
| fc_out | output | 4 | Operation code toward the processing unit |
| data_out | output | 16 | Operand toward the processing unit |
| ans_wait | output | 1 | Waiting for an answer |
| answer | input | 16 | Result from the processing unit |
| cc_bus | input | 3 | Condition flags, one-hot |
| load_req | output | 1 | Frame load requested |
| load_frame | output | 4 | Number of the requested frame |
| load_done | input | 1 | Requested frame is present on frame_bits |
| frame_bits | input | 464 | Wide frame contents |
| err | output | 1 | Sticky error for a condition bus that was not one-hot |

## Verification
The tightest overlap is an answer capture and a frame switch in the same cycle. The flagged branch pin points into another frame while the answer is being written into a data register. The bench provokes this by flagging "less than zero" with a branch successor in frame 2. It then checks that load_req names frame 2, that pin_addr stays frozen during the stall, and that the first send after the load carries the answer written in the branching cycle. A second overlap is a malformed condition bus followed by a valid one. It is judged by err staying set and by pin_addr and ans_wait staying unchanged.

// File: rtl/pinseq_pkg.sv
// Shared types for the successor-linked sequencer.
// Assumes the pin kind occupies the two top bits of the local pin field.
package pinseq_pkg;
    typedef enum logic [1:0] {
        KIND_SEND0 = 2'b00,
        KIND_SEND1 = 2'b01,
        KIND_OPEN  = 2'b10,
        KIND_HALT  = 2'b11
    } pin_kind_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WAIT_ANS,
        ST_WAIT_LOAD
    } seq_state_t;
endpackage

// File: rtl/pinseq_decode.sv
// Splits a local pin number into its kind and its register index.
// Assumes LOCAL_W - 2 >= REG_W; the bits in between are ignored.
module pinseq_decode
    import pinseq_pkg::*;
#(
    parameter int LOCAL_W = 6,
    parameter int REG_W   = 3
) (
    input  logic [LOCAL_W-1:0] local_i,
    output pin_kind_t          kind_o,
    output logic [REG_W-1:0]   reg_o
);
    logic unused_bits;

    // Kind from the top bits, register index from the low bits.
    always_comb begin
        kind_o      = pin_kind_t'(local_i[LOCAL_W-1 -: 2]);
        reg_o       = local_i[REG_W-1:0];
        unused_bits = ^local_i;
    end
endmodule

// File: rtl/pinseq_ctrl_store.sv
// Holds the control registers of the loaded frame: operation codes,
// send successors and branch successors. Everything is replaced at once
// when load_en is high. Assumes a frame_bits layout of codes, then send
// successors, then branch successors.
module pinseq_ctrl_store #(
    parameter int NUM_REGS = 8,
    parameter int FC_W     = 4,
    parameter int ADDR_W   = 10,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int SN_OFF  = NUM_REGS * 2 * FC_W,
    localparam int CC_OFF  = SN_OFF + NUM_REGS * 2 * ADDR_W,
    localparam int FRAME_BITS = CC_OFF + NUM_REGS * 3 * ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [FRAME_BITS-1:0] frame_bits,
    input  logic [REG_W-1:0]      send_reg,
    input  logic                  send_slot,
    input  logic [REG_W-1:0]      br_reg,
    input  logic [1:0]            br_cond,
    output logic [FC_W-1:0]       fc_o,
    output logic [ADDR_W-1:0]     send_next_o,
    output logic [ADDR_W-1:0]     br_next_o
);
    logic [FC_W-1:0]   fc_q  [NUM_REGS][2];
    logic [ADDR_W-1:0] snx_q [NUM_REGS][2];
    logic [ADDR_W-1:0] brn_q [NUM_REGS][3];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar s = 0; s < 2; s++) begin : g_slot
            // Code and successor of one send slot, replaced on load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fc_q[r][s]  <= '0;
                    snx_q[r][s] <= '0;
                end else if (load_en) begin
                    fc_q[r][s]  <= frame_bits[(2*r+s)*FC_W +: FC_W];
                    snx_q[r][s] <= frame_bits[SN_OFF + (2*r+s)*ADDR_W +: ADDR_W];
                end
            end
        end
        for (genvar c = 0; c < 3; c++) begin : g_cond
            // Successor of one branch pin, replaced on load.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    brn_q[r][c] <= '0;
                else if (load_en)
                    brn_q[r][c] <= frame_bits[CC_OFF + (3*r+c)*ADDR_W +: ADDR_W];
            end
        end
    end

    // Read ports for the firing send pin and the flagged branch pin.
    always_comb begin
        fc_o        = fc_q[send_reg][send_slot];
        send_next_o = snx_q[send_reg][send_slot];
        br_next_o   = (br_cond == 2'd3) ? '0 : brn_q[br_reg][br_cond];
    end
endmodule

// File: rtl/pinseq_data_rf.sv
// Data registers: one write port fed from the answer bus, one read port
// feeding the operand bus. A frame load never writes here.
module pinseq_data_rf #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  rsel,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_dreg
        // Capture an answer into register r.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[r] <= '0;
            else if (we && wsel == REG_W'(r))
                regs_q[r] <= wdata;
        end
    end

    // Operand read.
    assign rdata = regs_q[rsel];
endmodule

// File: rtl/pinseq_top.sv
// Successor-linked sequencer. Exactly one pin fires per cycle from the
// registered pin-address bus. Send pins issue a code and an operand. Open
// pins wait for a one-hot condition answer that picks a branch pin. An
// address in another frame stalls until that frame has been loaded.
// Assumes the processing unit drives answer and cc_bus only while ans_wait is high.
module pinseq_top
    import pinseq_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int FC_W     = 4,
    parameter int LOCAL_W  = 6,
    parameter int FRAME_W  = 4,
    localparam int ADDR_W  = FRAME_W + LOCAL_W,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int FRAME_BITS = NUM_REGS * (2 * FC_W + 5 * ADDR_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [ADDR_W-1:0]     pin_addr,
    output logic                  send_valid,
    output logic [FC_W-1:0]       fc_out,
    output logic [DATA_W-1:0]     data_out,
    output logic                  ans_wait,
    input  logic [DATA_W-1:0]     answer,
    input  logic [2:0]            cc_bus,
    output logic                  load_req,
    output logic [FRAME_W-1:0]    load_frame,
    input  logic                  load_done,
    input  logic [FRAME_BITS-1:0] frame_bits,
    output logic                  err
);
    seq_state_t          state_q;
    logic [ADDR_W-1:0]   pin_q;
    logic [FRAME_W-1:0]  cur_frame_q, req_frame_q;
    logic [REG_W-1:0]    sel_reg_q;
    logic                err_q;

    pin_kind_t           kind;
    logic [REG_W-1:0]    pin_reg;
    logic [FRAME_W-1:0]  pin_frame;
    logic                need_load, cc_onehot, take_answer, do_load;
    logic [1:0]          cc_idx;
    logic [ADDR_W-1:0]   send_next, br_next;

    pinseq_decode #(.LOCAL_W(LOCAL_W), .REG_W(REG_W)) u_dec (
        .local_i (pin_q[LOCAL_W-1:0]),
        .kind_o  (kind),
        .reg_o   (pin_reg)
    );

    // Frame check, condition decode and firing qualifiers.
    always_comb begin
        pin_frame   = pin_q[ADDR_W-1 -: FRAME_W];
        need_load   = (pin_frame != '0) && (pin_frame != cur_frame_q);
        cc_onehot   = (cc_bus != 3'b000) && ((cc_bus & (cc_bus - 3'b001)) == 3'b000);
        cc_idx      = cc_bus[2] ? 2'd2 : (cc_bus[1] ? 2'd1 : 2'd0);
        take_answer = (state_q == ST_WAIT_ANS) && !err_q && cc_onehot;
        do_load     = (state_q == ST_WAIT_LOAD) && load_done;
        send_valid  = (state_q == ST_RUN) && !need_load &&
                      (kind == KIND_SEND0 || kind == KIND_SEND1);
    end

    pinseq_ctrl_store #(.NUM_REGS(NUM_REGS), .FC_W(FC_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (do_load),
        .frame_bits  (frame_bits),
        .send_reg    (pin_reg),
        .send_slot   (kind == KIND_SEND1),
        .br_reg      (sel_reg_q),
        .br_cond     (cc_idx),
        .fc_o        (fc_out),
        .send_next_o (send_next),
        .br_next_o   (br_next)
    );

    pinseq_data_rf #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take_answer),
        .wsel  (sel_reg_q),
        .wdata (answer),
        .rsel  (pin_reg),
        .rdata (data_out)
    );

    // Sequencing: fire the current pin, wait for an answer, or wait for a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_WAIT_LOAD;
            pin_q       <= '0;
            cur_frame_q <= '0;
            req_frame_q <= '0;
            sel_reg_q   <= '0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (need_load) begin
                        state_q     <= ST_WAIT_LOAD;
                        req_frame_q <= pin_frame;
                    end else if (send_valid) begin
                        pin_q <= send_next;
                    end else if (kind == KIND_OPEN) begin
                        sel_reg_q <= pin_reg;
                        state_q   <= ST_WAIT_ANS;
                    end
                end
                ST_WAIT_ANS: begin
                    if (take_answer) begin
                        pin_q   <= br_next;
                        state_q <= ST_RUN;
                    end else if (cc_bus != 3'b000) begin
                        err_q <= 1'b1;
                    end
                end
                ST_WAIT_LOAD: begin
                    if (do_load) begin
                        cur_frame_q <= req_frame_q;
                        state_q     <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        pin_addr   = pin_q;
        ans_wait   = (state_q == ST_WAIT_ANS);
        load_req   = (state_q == ST_WAIT_LOAD);
        load_frame = req_frame_q;
        err        = err_q;
    end
endmodule

// File: rtl/pinseq_checker.sv
// Temporal checks on the sequencer's ports, attached through bind.
module pinseq_checker #(
    parameter int ADDR_W  = 10,
    parameter int FRAME_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  pin_addr,
    input logic               send_valid,
    input logic               ans_wait,
    input logic               load_req,
    input logic [FRAME_W-1:0] load_frame,
    input logic               load_done,
    input logic [2:0]         cc_bus,
    input logic               err
);
    // R4: a send never overlaps waiting for an answer or for a frame.
    assert_single_activity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_valid, ans_wait, load_req}));

    // R7: an empty condition bus keeps the block waiting at the same pin.
    assert_idle_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_wait && cc_bus == 3'b000) |=> (ans_wait && $stable(pin_addr)));

    // R8: a stalled frame request holds the address and the frame number.
    assert_load_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_done) |=> (load_req && $stable(pin_addr) && $stable(load_frame)));

    // R10: the error flag is sticky and freezes the sequencer.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && ans_wait && $stable(pin_addr)));

    // R10: only a malformed condition bus while waiting can raise err.
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(ans_wait && cc_bus != 3'b000 && $countones(cc_bus) > 1));
endmodule

bind pinseq_top pinseq_checker #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_pinseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_addr   (pin_addr),
    .send_valid (send_valid),
    .ans_wait   (ans_wait),
    .load_req   (load_req),
    .load_frame (load_frame),
    .load_done  (load_done),
    .cc_bus     (cc_bus),
    .err        (err)
);

// File: tb/tb_pinseq_top.sv
// Scoreboard bench: expected sends are queued by a driver task, and a
// monitor compares each send the design makes against the queue.
module tb_pinseq_top;
    localparam int NR = 8, DW = 16, FW = 4, AW = 10;
    localparam int FB = NR * (2 * FW + 5 * AW);
    localparam int SN_OFF = NR * 2 * FW;
    localparam int CC_OFF = SN_OFF + NR * 2 * AW;
    localparam logic [AW-1:0] HALT_PIN = 10'd48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pin_addr;
    logic          send_valid, ans_wait, load_req, err;
    logic [FW-1:0] fc_out;
    logic [DW-1:0] data_out, answer = '0;
    logic [2:0]    cc_bus = '0;
    logic [3:0]    load_frame;
    logic          load_done = 1'b0;
    logic [FB-1:0] frame_bits = '0;

    int checks = 0, fails = 0, cycles = 0;
    logic [FW+DW-1:0] exp_q[$];

    logic [FW-1:0] fcv [NR][2];
    logic [AW-1:0] snv [NR][2];
    logic [AW-1:0] ccv [NR][3];

    pinseq_top dut (
        .clk(clk), .rst_n(rst_n), .pin_addr(pin_addr), .send_valid(send_valid),
        .fc_out(fc_out), .data_out(data_out), .ans_wait(ans_wait), .answer(answer),
        .cc_bus(cc_bus), .load_req(load_req), .load_frame(load_frame),
        .load_done(load_done), .frame_bits(frame_bits), .err(err)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_send(input logic [FW-1:0] fc, input logic [DW-1:0] d);
        exp_q.push_back({fc, d});
    endtask

    // Monitor: every send must match the next queued item.
    always @(negedge clk) begin
        if (rst_n && send_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected send", {12'd0, fc_out, data_out}, 32'hDEAD);
            end else begin
                logic [FW+DW-1:0] e;
                e = exp_q.pop_front();
                check("R4 send fc/data", {12'd0, fc_out, data_out}, {12'd0, e});
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic clear_frame();
        for (int r = 0; r < NR; r++) begin
            for (int s = 0; s < 2; s++) begin fcv[r][s] = '0; snv[r][s] = HALT_PIN; end
            for (int c = 0; c < 3; c++) ccv[r][c] = HALT_PIN;
        end
    endtask

    function automatic logic [FB-1:0] pack_frame();
        logic [FB-1:0] f = '0;
        for (int r = 0; r < NR; r++) begin
            for (int s = 0; s < 2; s++) begin
                f[(2*r+s)*FW +: FW] = fcv[r][s];
                f[SN_OFF + (2*r+s)*AW +: AW] = snv[r][s];
            end
            for (int c = 0; c < 3; c++) f[CC_OFF + (3*r+c)*AW +: AW] = ccv[r][c];
        end
        return f;
    endfunction

    task automatic wait_ans();
        for (int i = 0; i < 50 && !ans_wait; i++) @(negedge clk);
    endtask

    task automatic wait_load();
        for (int i = 0; i < 50 && !load_req; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check("R1 load_req", load_req, 1);
        check("R1 load_frame", load_frame, 0);
        check("R1 pin_addr", pin_addr, 0);
        check("R1 err", err, 0);
        check("R1 send_valid", send_valid, 0);

        // Frame 0: pin0 sends r0 slot0, opens r1; r1 answers branch.
        clear_frame();
        fcv[0][0] = 4'd3;  snv[0][0] = 10'd33;
        fcv[1][1] = 4'd5;  snv[1][1] = 10'd33;
        ccv[1][1] = 10'd17;
        ccv[1][0] = {4'd2, 6'd1};
        frame_bits = pack_frame();
        expect_send(4'd3, 16'h0000);   // R2 first pin fires after load, R1 data zero
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        wait_ans();
        check("R5 open waits", ans_wait, 1);
        check("R3 open pin address", pin_addr, 33);
        // R7: empty condition bus keeps waiting
        repeat (3) begin
            @(negedge clk);
            check("R7 still waiting", ans_wait, 1);
            check("R7 pin stable", pin_addr, 33);
        end
        // R6: zero flag takes branch to send r1 slot1
        answer = 16'h0123; cc_bus = 3'b010;
        expect_send(4'd5, 16'h0123);
        @(negedge clk);
        cc_bus = 3'b000;
        check("R6 zero branch target", pin_addr, 17);
        wait_ans();
        // R6/R9: less-than flag branches into frame 2, answer written same cycle
        answer = 16'hFF00; cc_bus = 3'b001;
        @(negedge clk);
        cc_bus = 3'b000;
        check("R6 lt branch target", pin_addr, {4'd2, 6'd1});
        wait_load();
        check("R8 load_frame", load_frame, 2);
        check("R8 pin held", pin_addr, {4'd2, 6'd1});
        repeat (2) begin
            @(negedge clk);
            check("R8 still stalled", load_req, 1);
            check("R8 no send while stalled", send_valid, 0);
        end
        // Frame 2: send r1 slot0, successor in current frame (field 0)
        clear_frame();
        fcv[1][0] = 4'd9; snv[1][0] = 10'd34;
        frame_bits = pack_frame();
        expect_send(4'd9, 16'hFF00);   // R9 data kept across load
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        wait_ans();
        check("R8 frame 0 means current", pin_addr, 34);
        check("R8 no reload", load_req, 0);
        // R10: malformed condition bus
        cc_bus = 3'b011;
        @(negedge clk);
        check("R10 err set", err, 1);
        cc_bus = 3'b100;
        repeat (2) @(negedge clk);
        cc_bus = 3'b000;
        check("R10 err sticky", err, 1);
        check("R10 state held", ans_wait, 1);
        check("R10 pin held", pin_addr, 34);
        check("R4 queue drained", exp_q.size(), 0);

        // Second run: halt pin.
        do_reset();
        check("R1 err cleared", err, 0);
        clear_frame();
        fcv[0][0] = 4'd7;
        frame_bits = pack_frame();
        expect_send(4'd7, 16'h0000);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R11 halt holds pin", pin_addr, HALT_PIN);
            check("R11 halt no send", send_valid, 0);
        end
        check("R4 queue drained at end", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule